// File: doc/BRIEF.md
# Cache Error Address Capture Register

This block is a 64-bit read-only status register for a backup cache controller. On every cache access it records the tag, the tag-store parity, the bus-predicted tag parity and the cache map index of the location that was touched. The register has two 32-bit halves. The upper half belongs to longwords 3 and 1, and the lower half belongs to longwords 2 and 0. When an uncorrectable check-code error hits one longword pair, the matching half gives the address of the failing line.

Any reported error freezes the register: a tag parity error, a control-store parity error, or an uncorrectable check-code error on either longword pair. The register then stays frozen until the error-status register has cleared both its uncorrectable and parity-error bits. The predicted-parity bit of each half only locks when the error comes during a cycle type that applies to that half. With other cycle types it keeps following the bus. While the register is not frozen, a CSR read returns, in both predicted-parity positions, the even parity of the address bits presented with that read. This gives power-up diagnostics a view into the internal parity tree.

Top module: `cache_err_addr_capture`

## Requirements
- R1: After reset every stored field is zero, so a read whose address has an even number of one bits returns all zeros.
- R2: Each half is laid out as bit 31 (half-relative) reading zero, bits 30:19 tag, bit 18 tag parity, bit 17 predicted parity, and bits 16:0 map index. The upper half sits at 63:32 and the lower half at 31:0.
- R3: While not frozen, an access captures each half's tag, tag parity and map index. The map index is the line address bits 21:5, supplied as is, and is the same for both halves.
- R4: Any one of `err_tag_par`, `err_ctl_par`, `err_unc_hi` or `err_unc_lo` freezes the register. The fields keep the values of the access that arrived with the error, and later accesses have no effect on them.
- R5: The register stays frozen while `sts_unc` or `sts_par` is high. If both are sampled low at edge k, the register is still frozen at edge k+1, and an access at edge k+2 is captured again.
- R6: Cycle codes are 0 other, 1 bus read, 2 bus write, 3 bus exchange, 4 victim write, 5 masked write to a shared line, 6 load-locked/store-conditional, and 7 line victimization. An error during codes 1 to 7 locks the upper predicted-parity bit. Only codes 1 to 3 lock the lower one. An unlocked bit keeps taking the access's predicted parity even while the register is frozen.
- R7: A read while unfrozen returns the XOR of all `csr_addr` bits in bits 49 and 17. A read while frozen returns the stored predicted parities there.
- R8: `rd_data` is loaded at the clock edge where `csr_rd` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_vld | input | 1 | Cache access strobe |
| acc_idx | input | IDX_W | Line address bits 21:5 of the access |
| acc_cyc | input | 3 | Cycle type code (R6) |
| acc_tag_hi | input | TAG_W | Tag read for longwords 3/1 |
| acc_tpar_hi | input | 1 | Tag-store parity, upper half |
| acc_ppar_hi | input | 1 | Bus-predicted tag parity, upper half |
| acc_tag_lo | input | TAG_W | Tag read for longwords 2/0 |
| acc_tpar_lo | input | 1 | Tag-store parity, lower half |
| acc_ppar_lo | input | 1 | Bus-predicted tag parity, lower half |
| err_tag_par | input | 1 | Tag parity error pulse |
| err_ctl_par | input | 1 | Control-store parity error pulse |
| err_unc_hi | input | 1 | Uncorrectable error in longword 3 or 1 |
| err_unc_lo | input | 1 | Uncorrectable error in longword 2 or 0 |
| sts_unc | input | 1 | Uncorrectable status bit from the error-status register |
| sts_par | input | 1 | Parity-error status bit from the error-status register |
| csr_rd | input | 1 | CSR read strobe |
| csr_addr | input | ADDR_W | Address presented with the CSR read |
| rd_data | output | 64 | Registered read value |

## Verification
The parity tree is driven with a walking one across every `csr_addr` bit and with walking pairs. This separates a missing or duplicated tree leaf from a tree that was wired with the wrong polarity. Captures are swept through tag, parity and index patterns, including all-ones fields, which shows up any field placed in the wrong bit position and any leak into the two zero bits. Each of the four error sources is used in turn, and a staggered clearing of the status bits is applied, which tells a correct release delay from one that is a cycle early or late. All eight cycle codes are paired with an error, and each is followed by an access with the opposite predicted parity, which shows which codes lock each half.

// File: rtl/cea_pkg.sv
package cea_pkg;

   localparam int CYC_W = 3;
   localparam int CYC_N = 1 << CYC_W;

   typedef enum logic [CYC_W-1:0] {
      CYC_OTHER     = 3'd0,
      CYC_BUS_RD    = 3'd1,
      CYC_BUS_WR    = 3'd2,
      CYC_BUS_XCHG  = 3'd3,
      CYC_VICT_WR   = 3'd4,
      CYC_MASK_SHWR = 3'd5,
      CYC_LOCK      = 3'd6,
      CYC_VICTIMIZE = 3'd7
   } cyc_e;

   // one bit per cycle code: set when an error in that cycle locks predicted parity
   localparam logic [CYC_N-1:0] QUAL_UPPER =
      (CYC_N'(1) << CYC_BUS_RD)    | (CYC_N'(1) << CYC_BUS_WR)    |
      (CYC_N'(1) << CYC_BUS_XCHG)  | (CYC_N'(1) << CYC_VICT_WR)   |
      (CYC_N'(1) << CYC_MASK_SHWR) | (CYC_N'(1) << CYC_LOCK)      |
      (CYC_N'(1) << CYC_VICTIMIZE);

   localparam logic [CYC_N-1:0] QUAL_LOWER =
      (CYC_N'(1) << CYC_BUS_RD) | (CYC_N'(1) << CYC_BUS_WR) |
      (CYC_N'(1) << CYC_BUS_XCHG);

endpackage

// File: rtl/cea_parity_tree.sv
module cea_parity_tree #(
   parameter int W = 34
) (
   input  logic [W-1:0] vec,
   output logic         par
);
   localparam int LV     = (W > 1) ? $clog2(W) : 0;
   localparam int LEAVES = 1 << LV;

   generate
      if (W < 1) begin : g_bad_w
         $error("cea_parity_tree: W must be at least 1");
      end

      for (genvar l = 0; l <= LV; l++) begin : g_lvl
         logic [(LEAVES >> l)-1:0] v;
         if (l == 0) begin : g_leaf
            for (genvar i = 0; i < LEAVES; i++) begin : g_in
               if (i < W) begin : g_real
                  assign v[i] = vec[i];
               end else begin : g_pad
                  assign v[i] = 1'b0;
               end
            end
         end else begin : g_node
            for (genvar j = 0; j < (LEAVES >> l); j++) begin : g_xor
               assign v[j] = g_lvl[l-1].v[2*j] ^ g_lvl[l-1].v[2*j+1];
            end
         end
      end
   endgenerate

   assign par = g_lvl[LV].v[0];

endmodule

// File: rtl/cea_freeze_ctl.sv
module cea_freeze_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic err_any,
   input  logic sts_unc,
   input  logic sts_par,
   output logic frz_q,
   output logic rel
);
   logic clr_q;
   logic frz_d;

   // hold once set; the status-clear observation from the previous edge releases
   always_comb begin
      frz_d = err_any | (frz_q & ~clr_q);
      rel   = frz_q & clr_q & ~err_any;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frz_q <= 1'b0;
         clr_q <= 1'b0;
      end else begin
         frz_q <= frz_d;
         clr_q <= ~sts_unc & ~sts_par;
      end
   end

endmodule

// File: rtl/cea_half.sv
module cea_half import cea_pkg::*; #(
   parameter int                TAG_W     = 12,
   parameter int                IDX_W     = 17,
   parameter int                HALF_W    = 32,
   parameter logic [CYC_N-1:0]  QUAL_MASK = QUAL_LOWER
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              acc_vld,
   input  logic [CYC_W-1:0]  acc_cyc,
   input  logic [TAG_W-1:0]  tag_in,
   input  logic              tpar_in,
   input  logic              ppar_in,
   input  logic [IDX_W-1:0]  idx_in,
   input  logic              err_any,
   input  logic              rel,
   input  logic              use_live,
   input  logic              live_par,
   output logic [HALF_W-1:0] word,
   output logic [TAG_W-1:0]  tag_o
);
   localparam int FIELD_W = TAG_W + IDX_W + 2;
   localparam int PP_POS  = IDX_W;
   localparam int TP_POS  = IDX_W + 1;
   localparam int TAG_LSB = IDX_W + 2;

   logic [TAG_W-1:0] tag_q;
   logic [IDX_W-1:0] idx_q;
   logic             tpar_q;
   logic             ppar_q;
   logic             hold_q;
   logic             qual;
   logic             hold_d;
   logic             pp_upd;

   always_comb begin
      qual   = QUAL_MASK[acc_cyc];
      hold_d = rel ? 1'b0 : (hold_q | (err_any & qual));
      pp_upd = acc_vld & ~hold_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q  <= '0;
         idx_q  <= '0;
         tpar_q <= 1'b0;
      end else if (cap_en) begin
         tag_q  <= tag_in;
         idx_q  <= idx_in;
         tpar_q <= tpar_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ppar_q <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         hold_q <= hold_d;
         if (pp_upd) begin
            ppar_q <= ppar_in;
         end
      end
   end

   assign word[IDX_W-1:0]         = idx_q;
   assign word[PP_POS]            = use_live ? live_par : ppar_q;
   assign word[TP_POS]            = tpar_q;
   assign word[TAG_LSB +: TAG_W]  = tag_q;
   assign tag_o                   = tag_q;

   generate
      if (HALF_W > FIELD_W) begin : g_pad
         assign word[HALF_W-1:FIELD_W] = '0;
      end
   endgenerate

endmodule

// File: rtl/cache_err_addr_capture.sv
module cache_err_addr_capture import cea_pkg::*; #(
   parameter int TAG_W  = 12,
   parameter int IDX_W  = 17,
   parameter int ADDR_W = 34,
   parameter int RD_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_vld,
   input  logic [IDX_W-1:0]  acc_idx,
   input  logic [CYC_W-1:0]  acc_cyc,
   input  logic [TAG_W-1:0]  acc_tag_hi,
   input  logic              acc_tpar_hi,
   input  logic              acc_ppar_hi,
   input  logic [TAG_W-1:0]  acc_tag_lo,
   input  logic              acc_tpar_lo,
   input  logic              acc_ppar_lo,
   input  logic              err_tag_par,
   input  logic              err_ctl_par,
   input  logic              err_unc_hi,
   input  logic              err_unc_lo,
   input  logic              sts_unc,
   input  logic              sts_par,
   input  logic              csr_rd,
   input  logic [ADDR_W-1:0] csr_addr,
   output logic [RD_W-1:0]   rd_data
);
   localparam int HALF_W  = RD_W / 2;
   localparam int FIELD_W = TAG_W + IDX_W + 2;
   localparam int N_HALF  = 2;

   generate
      if (RD_W % 2 != 0) begin : g_bad_rd
         $error("cache_err_addr_capture: RD_W must be even");
      end
      if (FIELD_W > HALF_W) begin : g_bad_fit
         $error("cache_err_addr_capture: tag and index do not fit a half");
      end
   endgenerate

   logic err_any;
   logic frz_q;
   logic rel;
   logic live_par;
   logic cap_en;
   logic use_live;

   assign err_any  = err_tag_par | err_ctl_par | err_unc_hi | err_unc_lo;
   assign cap_en   = acc_vld & ~frz_q;
   assign use_live = ~frz_q;

   cea_freeze_ctl u_frz (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_any (err_any),
      .sts_unc (sts_unc),
      .sts_par (sts_par),
      .frz_q   (frz_q),
      .rel     (rel)
   );

   cea_parity_tree #(.W(ADDR_W)) u_ptree (
      .vec (csr_addr),
      .par (live_par)
   );

   // index 1 = upper half (longwords 3/1), index 0 = lower half (longwords 2/0)
   logic [TAG_W-1:0]  tag_in   [N_HALF];
   logic              tpar_in  [N_HALF];
   logic              ppar_in  [N_HALF];
   logic [HALF_W-1:0] word     [N_HALF];
   logic [TAG_W-1:0]  tag_arr  [N_HALF];

   assign tag_in[1]  = acc_tag_hi;
   assign tag_in[0]  = acc_tag_lo;
   assign tpar_in[1] = acc_tpar_hi;
   assign tpar_in[0] = acc_tpar_lo;
   assign ppar_in[1] = acc_ppar_hi;
   assign ppar_in[0] = acc_ppar_lo;

   generate
      for (genvar h = 0; h < N_HALF; h++) begin : g_half
         cea_half #(
            .TAG_W     (TAG_W),
            .IDX_W     (IDX_W),
            .HALF_W    (HALF_W),
            .QUAL_MASK ((h == 1) ? QUAL_UPPER : QUAL_LOWER)
         ) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (cap_en),
            .acc_vld  (acc_vld),
            .acc_cyc  (acc_cyc),
            .tag_in   (tag_in[h]),
            .tpar_in  (tpar_in[h]),
            .ppar_in  (ppar_in[h]),
            .idx_in   (acc_idx),
            .err_any  (err_any),
            .rel      (rel),
            .use_live (use_live),
            .live_par (live_par),
            .word     (word[h]),
            .tag_o    (tag_arr[h])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (csr_rd) begin
         rd_data <= {word[1], word[0]};
      end
   end

endmodule

// File: rtl/cea_checker.sv
module cea_checker #(
   parameter int TAG_W  = 12,
   parameter int IDX_W  = 17,
   parameter int ADDR_W = 34,
   parameter int RD_W   = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              err_tag_par,
   input logic              err_ctl_par,
   input logic              err_unc_hi,
   input logic              err_unc_lo,
   input logic              sts_unc,
   input logic              sts_par,
   input logic              csr_rd,
   input logic [ADDR_W-1:0] csr_addr,
   input logic [RD_W-1:0]   rd_data,
   input logic              frz_q,
   input logic [TAG_W-1:0]  tag_hi
);
   localparam int HALF_W = RD_W / 2;

   // R2
   pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[RD_W-1] == 1'b0) && (rd_data[HALF_W-1] == 1'b0));

   // R4
   err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_tag_par || err_ctl_par || err_unc_hi || err_unc_lo) |=> frz_q);

   // R4
   frozen_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frz_q |=> $stable(tag_hi));

   // R5
   sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q && (sts_unc || sts_par)) |=> frz_q);

   // R7
   live_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && !frz_q) |=>
         (rd_data[IDX_W] == $past(^csr_addr)) &&
         (rd_data[HALF_W + IDX_W] == $past(^csr_addr)));

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_rd |=> $stable(rd_data));

endmodule

bind cache_err_addr_capture cea_checker #(
   .TAG_W  (TAG_W),
   .IDX_W  (IDX_W),
   .ADDR_W (ADDR_W),
   .RD_W   (RD_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .err_tag_par (err_tag_par),
   .err_ctl_par (err_ctl_par),
   .err_unc_hi  (err_unc_hi),
   .err_unc_lo  (err_unc_lo),
   .sts_unc     (sts_unc),
   .sts_par     (sts_par),
   .csr_rd      (csr_rd),
   .csr_addr    (csr_addr),
   .rd_data     (rd_data),
   .frz_q       (frz_q),
   .tag_hi      (tag_arr[1])
);

// File: tb/cache_err_addr_capture_tb.sv
`timescale 1ns/1ps
module cache_err_addr_capture_tb;
   localparam int TAG_W  = 12;
   localparam int IDX_W  = 17;
   localparam int ADDR_W = 34;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              d_acc = 1'b0;
   logic [IDX_W-1:0]  d_idx = '0;
   logic [2:0]        d_cyc = '0;
   logic [TAG_W-1:0]  d_tag_hi = '0, d_tag_lo = '0;
   logic              d_tp_hi = 1'b0, d_tp_lo = 1'b0;
   logic              d_pp_hi = 1'b0, d_pp_lo = 1'b0;
   logic [3:0]        d_err = '0;   // [0] tag par, [1] ctl par, [2] unc lo, [3] unc hi
   logic              d_su = 1'b0, d_sp = 1'b0;
   logic              d_rd = 1'b0;
   logic [ADDR_W-1:0] d_ra = '0;
   logic [63:0]       rd_data;

   always #4 clk = ~clk;

   cache_err_addr_capture u_dut (
      .clk(clk), .rst_n(rst_n), .acc_vld(d_acc), .acc_idx(d_idx), .acc_cyc(d_cyc),
      .acc_tag_hi(d_tag_hi), .acc_tpar_hi(d_tp_hi), .acc_ppar_hi(d_pp_hi),
      .acc_tag_lo(d_tag_lo), .acc_tpar_lo(d_tp_lo), .acc_ppar_lo(d_pp_lo),
      .err_tag_par(d_err[0]), .err_ctl_par(d_err[1]), .err_unc_lo(d_err[2]),
      .err_unc_hi(d_err[3]), .sts_unc(d_su), .sts_par(d_sp),
      .csr_rd(d_rd), .csr_addr(d_ra), .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // expected state, built from the requirements
   logic [TAG_W-1:0] m_tag [2];
   logic             m_tp  [2];
   logic             m_pp  [2];
   logic             m_hold[2];
   logic [IDX_W-1:0] m_idx = '0;
   logic             m_frz = 1'b0;
   logic             m_clr = 1'b0;
   logic [63:0]      last_rd = '0;

   function automatic logic [31:0] half_exp(int h, logic live, logic lp);
      return {1'b0, m_tag[h], m_tp[h], (live ? lp : m_pp[h]), m_idx};
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s rd_data=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(string req);
      logic [63:0] exp;
      logic        e, rel, q, frz_n;
      logic [1:0]  hold_n;
      logic        pin [2];
      exp = '0;
      if (d_rd) exp = {half_exp(1, !m_frz, ^d_ra), half_exp(0, !m_frz, ^d_ra)};
      pin[1] = d_pp_hi;
      pin[0] = d_pp_lo;
      e   = |d_err;
      rel = m_frz && m_clr && !e;
      for (int h = 0; h < 2; h++) begin
         // R6: upper locks on codes 1..7, lower on codes 1..3
         q = (h == 1) ? (d_cyc != 3'd0) : (d_cyc >= 3'd1 && d_cyc <= 3'd3);
         hold_n[h] = rel ? 1'b0 : (m_hold[h] | (e & q));
      end
      if (d_acc && !m_frz) begin
         m_tag[1] = d_tag_hi; m_tp[1] = d_tp_hi;
         m_tag[0] = d_tag_lo; m_tp[0] = d_tp_lo;
         m_idx    = d_idx;
      end
      for (int h = 0; h < 2; h++) begin
         if (d_acc && !m_hold[h]) m_pp[h] = pin[h];
         m_hold[h] = hold_n[h];
      end
      frz_n = e | (m_frz & !m_clr);
      m_clr = !d_su && !d_sp;
      m_frz = frz_n;
      @(posedge clk);
      @(negedge clk);
      if (d_rd) begin
         chk(req, rd_data, exp);
         last_rd = rd_data;
      end
      d_acc = 1'b0;
      d_rd  = 1'b0;
      d_err = '0;
   endtask

   task automatic set_acc(logic [TAG_W-1:0] th, logic [TAG_W-1:0] tl, logic tph, logic tpl,
                          logic pph, logic ppl, logic [IDX_W-1:0] ix, logic [2:0] cy);
      d_acc = 1'b1; d_tag_hi = th; d_tag_lo = tl; d_tp_hi = tph; d_tp_lo = tpl;
      d_pp_hi = pph; d_pp_lo = ppl; d_idx = ix; d_cyc = cy;
   endtask

   task automatic rd_at(logic [ADDR_W-1:0] a, string req);
      d_rd = 1'b1;
      d_ra = a;
      tick(req);
   endtask

   initial begin
      for (int h = 0; h < 2; h++) begin
         m_tag[h] = '0; m_tp[h] = 1'b0; m_pp[h] = 1'b0; m_hold[h] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents, even-weight addresses
      rd_at('0, "R1");
      rd_at(34'h3, "R1");
      rd_at(34'h3_0000_0000, "R1");

      // R7: walking one and walking pair across every address bit while unfrozen
      for (int i = 0; i < ADDR_W; i++) rd_at(34'(1) << i, "R7");
      for (int i = 1; i < ADDR_W; i++) rd_at((34'(1) << i) | 34'(1), "R7");

      // R8: no read strobe, different address: output holds
      d_ra = 34'h1;
      tick("R8");
      chk("R8", rd_data, last_rd);
      set_acc('1, '1, 1'b1, 1'b1, 1'b1, 1'b1, '1, 3'd1);
      tick("R8");
      chk("R8", rd_data, last_rd);

      // R3 / R2: capture sweep including all-ones fields
      for (int k = 0; k < 20; k++) begin
         if (k == 0) set_acc('1, '1, 1'b1, 1'b1, 1'b1, 1'b1, '1, 3'd0);
         else set_acc(TAG_W'(k * 273), TAG_W'(~(k * 91)), k[0], k[1],
                      k[2], k[0], IDX_W'(k * 7919), 3'(k));
         tick("R3");
         rd_at('0, (k == 0) ? "R2" : "R3");
      end

      // R4 / R5: each error source freezes; staggered status release
      for (int s = 0; s < 4; s++) begin
         d_err = 4'(1) << s;
         if (s < 2) d_sp = 1'b1; else d_su = 1'b1;
         set_acc(TAG_W'(12'hA50 + s), TAG_W'(12'h05A + s), 1'b1, 1'b0,
                 1'b1, 1'b0, IDX_W'(17'h1_2340 + s), 3'd2);
         tick("R4");
         for (int j = 0; j < 3; j++) begin
            set_acc(TAG_W'(j + 5), TAG_W'(j + 9), 1'b0, 1'b1, 1'b0, 1'b1, IDX_W'(j), 3'd0);
            tick("R4");
         end
         rd_at(34'h1, "R4");
         if (s == 0) begin
            d_su = 1'b1;
            tick("R5");
            d_sp = 1'b0;
            set_acc(12'h111, 12'h222, 1'b0, 1'b0, 1'b0, 1'b0, 17'h0_0111, 3'd0);
            tick("R5");
            set_acc(12'h333, 12'h444, 1'b0, 1'b0, 1'b0, 1'b0, 17'h0_0333, 3'd0);
            tick("R5");
            rd_at(34'h1, "R5");
         end
         d_su = 1'b0;
         d_sp = 1'b0;
         set_acc(12'hC01, 12'hC02, 1'b0, 1'b1, 1'b0, 1'b0, 17'h0_0C01, 3'd0);
         tick("R5");
         d_rd = 1'b1; d_ra = 34'h1;
         set_acc(12'hD01, 12'hD02, 1'b1, 1'b0, 1'b0, 1'b0, 17'h0_0D01, 3'd0);
         tick("R5");
         set_acc(12'hE01, 12'hE02, 1'b1, 1'b1, 1'b0, 1'b0, 17'h0_0E01, 3'd0);
         tick("R5");
         rd_at(34'h1, "R5");
      end

      // R6: every cycle code with an error, then opposite predicted parity
      for (int c = 0; c < 8; c++) begin
         d_err = 4'b0001;
         d_sp  = 1'b1;
         set_acc(12'h7A7, 12'h5C5, 1'b0, 1'b0, 1'b1, 1'b1, 17'h1_5555, 3'(c));
         tick("R6");
         set_acc(12'h001, 12'h002, 1'b0, 1'b0, 1'b0, 1'b0, 17'h0_0001, 3'd0);
         tick("R6");
         rd_at('0, "R6");
         d_sp = 1'b0;
         tick("R6");
         tick("R6");
         rd_at(34'h7, "R7");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule